// File: doc/BRIEF.md
# Four-Pass Wide Signed Multiplier Lane

This lane forms the full 64-bit two's-complement product of two 32-bit signed operands. It has no 32x32 multiplier. It reuses one 16x16 multiply-accumulate datapath over four consecutive passes.

When a start strobe is accepted, a sequencer captures both operands and splits each one into an unsigned low half and a signed high half. It then steps through four passes. The first pass is a plain multiply. The next three add their product into the running 64-bit accumulator. Each pass is steered by a packed control word. The word sets the signedness of each operand, an optional left shift of the incoming accumulator by 16 bits, accumulator zeroing, and negation masks for the product and the accumulator.

The final sum is registered onto the result port, and a one-cycle done strobe marks it. The lane stays busy for four cycles and takes no new work during that time.

Top module: `wmul_lane`

## Requirements
- R1: When done is high, result equals the signed 64-bit product of the two 32-bit operands captured at the accepted start. Every 32-bit input pair, including the most negative value, gives the exact product.
- R2: done is high for exactly one cycle. It rises four rising clock edges after the edge that accepted start.
- R3: The lane ignores a start seen while an operation is in flight, including on the edge where done is produced. It gives no extra done, and the result of the running operation does not change.
- R4: result changes only on the edge that raises done. Between two done pulses it holds its value.
- R5: While reset is high, and in the first cycle after it, done is 0 and result is 0.
- R6: The low 16-bit half of each operand is multiplied as an unsigned number and the high half as a signed number. A low half with bit 15 set therefore contributes a positive value.
- R7: The passes run in a fixed order, each with its own control word. The field positions are: zero-accumulator bit 0, accumulator mode bits 2:1, precision mode bits 4:3, variant bits 7:5, Y sign bit 8, X sign bit 9, shift-by-16 bit 10, negate-product bit 11, negate-accumulator bit 12, negate-sum bit 13. The four passes are:
  - high x high, both signed, word 858.
  - high(A) x low(B) with a shift, word 1626.
  - low(A) x high(B) without a shift, word 346.
  - low x low with a shift, word 1114.
- R8: A start presented in the cycle right after done is accepted, so operations can run back to back every four cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when the lane is idle |
| op_a | input | 32 | Signed multiplicand, captured with start |
| op_b | input | 32 | Signed multiplier, captured with start |
| result | output | 64 | Signed product, valid while done is high and held afterwards |
| done | output | 1 | One-cycle strobe marking a fresh result |

## Verification
The bench uses several kinds of operand pairs, and each kind separates a different fault.

- Zero and one show whether the passes combine at all.
- Operands whose low half has bit 15 set, such as 0x0000FFFF squared, expose a low half wrongly treated as signed.
- Values that put a single bit in one half, such as 2^16 times 1, expose a shift applied in the wrong pass or a pass run in the wrong order.
- The most negative value squared, and that value times -1, exercise the sign handling of the high halves.
- A run of random pairs, issued back to back, covers mixed cases.

Starts held high during an operation show whether busy starts are really ignored.

// File: rtl/wmul_pkg.sv
package wmul_pkg;

  // control word field positions
  localparam int CW_W      = 32;
  localparam int CW_ZERO   = 0;
  localparam int CW_AMODE  = 1;
  localparam int CW_PMODE  = 3;
  localparam int CW_VAR    = 5;
  localparam int CW_SGN_Y  = 8;
  localparam int CW_SGN_X  = 9;
  localparam int CW_SHIFT  = 10;
  localparam int CW_NEG_P  = 11;
  localparam int CW_NEG_A1 = 12;
  localparam int CW_NEG_A2 = 13;
  localparam int CW_CMASK  = 16;

  localparam int NUM_PASSES = 4;
  localparam int PASS_W     = $clog2(NUM_PASSES);

  typedef logic [CW_W-1:0] cword_t;

  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_sel_e;

  typedef struct packed {
    half_sel_e sel_a;
    half_sel_e sel_b;
    cword_t    cw;
  } pass_plan_t;

  function automatic cword_t make_cword(
    input logic       sgn_x,
    input logic       sgn_y,
    input logic [1:0] amode,
    input logic [1:0] pmode,
    input logic [2:0] variant,
    input logic       zero_acc,
    input logic       shift16,
    input logic       neg_prod,
    input logic       neg_acc1,
    input logic       neg_acc2,
    input logic [3:0] cmask
  );
    cword_t w;
    w = '0;
    w[CW_ZERO]              = zero_acc;
    w[CW_AMODE +: 2]        = amode;
    w[CW_PMODE +: 2]        = pmode;
    w[CW_VAR +: 3]          = variant;
    w[CW_SGN_Y]             = sgn_y;
    w[CW_SGN_X]             = sgn_x;
    w[CW_SHIFT]             = shift16;
    w[CW_NEG_P]             = neg_prod;
    w[CW_NEG_A1]            = neg_acc1;
    w[CW_NEG_A2]            = neg_acc2;
    w[CW_CMASK +: 4]        = cmask;
    return w;
  endfunction

  // fixed four-pass schedule: hi*hi, hi(A)*lo(B), lo(A)*hi(B), lo*lo
  function automatic pass_plan_t pass_plan(input logic [PASS_W-1:0] idx);
    pass_plan_t p;
    case (idx)
      2'd0: begin
        p.sel_a = HALF_HI; p.sel_b = HALF_HI;
        p.cw = make_cword(1'b1, 1'b1, 2'd1, 2'd3, 3'd2, 1'b0, 1'b0,
                          1'b0, 1'b0, 1'b0, 4'd0);
      end
      2'd1: begin
        p.sel_a = HALF_HI; p.sel_b = HALF_LO;
        p.cw = make_cword(1'b1, 1'b0, 2'd1, 2'd3, 3'd2, 1'b0, 1'b1,
                          1'b0, 1'b0, 1'b0, 4'd0);
      end
      2'd2: begin
        p.sel_a = HALF_LO; p.sel_b = HALF_HI;
        p.cw = make_cword(1'b0, 1'b1, 2'd1, 2'd3, 3'd2, 1'b0, 1'b0,
                          1'b0, 1'b0, 1'b0, 4'd0);
      end
      default: begin
        p.sel_a = HALF_LO; p.sel_b = HALF_LO;
        p.cw = make_cword(1'b0, 1'b0, 2'd1, 2'd3, 3'd2, 1'b0, 1'b1,
                          1'b0, 1'b0, 1'b0, 4'd0);
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/wmul_mac16.sv
module wmul_mac16
  import wmul_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ACC_W  = 64
) (
  input  logic [HALF_W-1:0] x_half,
  input  logic [HALF_W-1:0] y_half,
  input  cword_t            cw,
  input  logic [ACC_W-1:0]  acc_in,
  output logic [ACC_W-1:0]  acc_out
);

  localparam int EXT_W  = HALF_W + 1;
  localparam int PROD_W = 2 * EXT_W;

  logic [HALF_W-1:0]       opnd [2];
  logic                    sgn  [2];
  logic signed [EXT_W-1:0] ext  [2];

  assign opnd[0] = x_half;
  assign opnd[1] = y_half;
  assign sgn[0]  = cw[CW_SGN_X];
  assign sgn[1]  = cw[CW_SGN_Y];

  // sign- or zero-extend each half to HALF_W+1 bits
  for (genvar k = 0; k < 2; k++) begin : g_ext
    assign ext[k] = {sgn[k] & opnd[k][HALF_W-1], opnd[k]};
  end

  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         prod_w;
  logic [ACC_W-1:0]         base_z;
  logic [ACC_W-1:0]         base_n;
  logic [ACC_W-1:0]         base_s;
  logic [ACC_W-1:0]         term;
  logic [ACC_W-1:0]         sum;

  assign prod   = ext[0] * ext[1];
  assign prod_w = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_comb begin
    base_z  = cw[CW_ZERO]   ? '0 : acc_in;
    base_n  = cw[CW_NEG_A1] ? (~base_z + 1'b1) : base_z;
    base_s  = cw[CW_SHIFT]  ? (base_n << HALF_W) : base_n;
    term    = cw[CW_NEG_P]  ? (~prod_w + 1'b1) : prod_w;
    sum     = base_s + term;
    acc_out = cw[CW_NEG_A2] ? (~sum + 1'b1) : sum;
  end

  // mode, precision, variant and complex-mask fields select nothing here
  logic unused_cw;
  assign unused_cw = ^{cw[CW_W-1:CW_NEG_A2+1], cw[CW_SGN_Y-1:CW_AMODE]};

endmodule

// File: rtl/wmul_seq.sv
module wmul_seq
  import wmul_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic              busy,
  output logic [PASS_W-1:0] pass,
  output logic              first,
  output logic              last,
  output logic [OP_W/2-1:0] x_half,
  output logic [OP_W/2-1:0] y_half,
  output cword_t            cw
);

  localparam int HALF_W = OP_W / 2;
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NUM_PASSES - 1);

  logic [OP_W-1:0] a_q;
  logic [OP_W-1:0] b_q;
  pass_plan_t      plan;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      pass <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else if (!busy) begin
      pass <= '0;
      if (start) begin
        busy <= 1'b1;
        a_q  <= op_a;
        b_q  <= op_b;
      end
    end else begin
      pass <= pass + 1'b1;
      if (pass == LAST_PASS) busy <= 1'b0;
    end
  end

  always_comb begin
    plan   = pass_plan(pass);
    x_half = (plan.sel_a == HALF_HI) ? a_q[OP_W-1:HALF_W] : a_q[HALF_W-1:0];
    y_half = (plan.sel_b == HALF_HI) ? b_q[OP_W-1:HALF_W] : b_q[HALF_W-1:0];
    cw     = plan.cw;
    first  = (pass == '0);
    last   = (pass == LAST_PASS);
  end

endmodule

// File: rtl/wmul_lane.sv
module wmul_lane
  import wmul_pkg::*;
#(
  parameter int OP_W  = 32,
  parameter int ACC_W = 2 * OP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  output logic [ACC_W-1:0] result,
  output logic             done
);

  localparam int HALF_W = OP_W / 2;

  logic              seq_busy;
  logic [PASS_W-1:0] seq_pass;
  logic              seq_first;
  logic              seq_last;
  logic [HALF_W-1:0] seq_x;
  logic [HALF_W-1:0] seq_y;
  cword_t            seq_cw;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  mac_in;
  logic [ACC_W-1:0]  mac_out;

  wmul_seq #(.OP_W(OP_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op_a   (op_a),
    .op_b   (op_b),
    .busy   (seq_busy),
    .pass   (seq_pass),
    .first  (seq_first),
    .last   (seq_last),
    .x_half (seq_x),
    .y_half (seq_y),
    .cw     (seq_cw)
  );

  // first pass is a plain multiply: no accumulator enters
  assign mac_in = seq_first ? '0 : acc_q;

  wmul_mac16 #(.HALF_W(HALF_W), .ACC_W(ACC_W)) u_mac (
    .x_half  (seq_x),
    .y_half  (seq_y),
    .cw      (seq_cw),
    .acc_in  (mac_in),
    .acc_out (mac_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (seq_busy) begin
        acc_q <= mac_out;
        if (seq_last) begin
          result <= mac_out;
          done   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wmul_lane_chk.sv
module wmul_lane_chk #(
  parameter int ACC_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             done,
  input logic [ACC_W-1:0] result,
  input logic             busy,
  input logic [1:0]       pass,
  input logic [31:0]      cw
);

  assert_reset_clear_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!done && result == '0));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_last_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && $past(pass) == 2'd3));

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && pass == 2'd0));

  assert_busy_advance_R3: assert property (@(posedge clk) disable iff (rst)
    busy |=> (pass == 2'($past(pass) + 2'd1)));

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);

  assert_cword_p0_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && pass == 2'd0) |-> (cw == 32'd858));
  assert_cword_p1_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && pass == 2'd1) |-> (cw == 32'd1626));
  assert_cword_p2_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && pass == 2'd2) |-> (cw == 32'd346));
  assert_cword_p3_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && pass == 2'd3) |-> (cw == 32'd1114));

endmodule

bind wmul_lane wmul_lane_chk #(.ACC_W(ACC_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .done   (done),
  .result (result),
  .busy   (seq_busy),
  .pass   (seq_pass),
  .cw     (seq_cw)
);

// File: tb/wmul_lane_bench.sv
module wmul_lane_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [63:0] result;
  logic        done;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wmul_lane u_wmul_lane (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op_a   (op_a),
    .op_b   (op_b),
    .result (result),
    .done   (done)
  );

  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] ea;
    logic signed [63:0] eb;
    ea = {{32{a[31]}}, a};
    eb = {{32{b[31]}}, b};
    return 64'(ea * eb);
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // called at a negedge with the lane idle; returns at the negedge after done
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input string req);
    start = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0; op_a = $urandom; op_b = $urandom;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check1("R2 done early", done, 1'b0);
    end
    @(negedge clk);
    check1("R2 done on fourth edge", done, 1'b1);
    check64(req, result, ref_mul(a, b));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check1("R5 done in reset", done, 1'b0);
    check64("R5 result in reset", result, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check1("R5 done after reset", done, 1'b0);
    check64("R5 result after reset", result, 64'd0);
  endtask

  task automatic t_corners;
    run_op(32'd0, 32'd12345, "R1 zero");
    run_op(32'd1, 32'd1, "R1 one");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 minus1 squared");
    run_op(32'h8000_0000, 32'h8000_0000, "R1 min squared");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, "R1 min times minus1");
    run_op(32'h7FFF_FFFF, 32'h8000_0000, "R1 max times min");
    run_op(32'hFFFF_FFFF, 32'd7, "R1 minus1 times 7");
  endtask

  task automatic t_sign_halves;
    run_op(32'h0000_FFFF, 32'h0000_FFFF, "R6 low halves unsigned");
    run_op(32'h0000_8000, 32'd1, "R6 low msb positive");
    run_op(32'hFFFF_8000, 32'h0000_8001, "R6 mixed halves");
  endtask

  task automatic t_pass_order;
    // R7: a single bit in one half shows where the shifts land
    run_op(32'h0001_0000, 32'd1, "R7 hi a times lo b");
    run_op(32'd1, 32'h0001_0000, "R7 lo a times hi b");
    run_op(32'h0001_0000, 32'h0001_0000, "R7 hi times hi");
  endtask

  task automatic t_random;
    // R8: consecutive run_op calls start right after each done
    for (int i = 0; i < 40; i++) begin
      run_op($urandom, $urandom, "R1 R8 random back to back");
    end
  endtask

  task automatic t_busy_ignore;
    logic [31:0] a;
    logic [31:0] b;
    a = 32'h1234_5678; b = 32'hFEDC_BA98;
    start = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      op_a = $urandom; op_b = $urandom;
      if (i < 3) check1("R3 no early done", done, 1'b0);
      @(negedge clk);
    end
    start = 1'b0;
    check1("R3 done once", done, 1'b1);
    check64("R3 result of first op", result, ref_mul(a, b));
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check1("R3 no extra done", done, 1'b0);
    end
  endtask

  task automatic t_hold;
    logic [63:0] exp;
    run_op(32'hDEAD_BEEF, 32'h0BAD_F00D, "R1 hold setup");
    exp = ref_mul(32'hDEAD_BEEF, 32'h0BAD_F00D);
    for (int i = 0; i < 5; i++) begin
      op_a = $urandom; op_b = $urandom;
      @(negedge clk);
      check64("R4 result held", result, exp);
    end
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    t_reset();
    t_corners();
    t_sign_halves();
    t_pass_order();
    t_busy_ignore();
    t_hold();
    t_random();
    repeat (2) @(negedge clk);
    finish_up();
  end

endmodule